// File: doc/BRIEF.md
# Dual-Bank Clock Divider with Coincidence Sync Pulse

This block takes one fast reference clock and produces two divided clocks, bank A and bank C. Each bank has its own integer divide ratio. Both dividers start on the same reference edge, so their rising edges line up at start-up and then at regular common edges. An active-low sync output warns of each coming common edge. It falls one period of the faster output before that edge and rises on the edge itself. System logic that moves data between the two clock domains can use it as a safe transfer marker. This matters most when the two ratios are not multiples of each other.

A control state machine has three states: CTL_HOLD (in reset), CTL_ALIGN (one cycle after reset release) and CTL_RUN (free running). Its transitions are HOLD to ALIGN on the first edge after reset release, ALIGN to RUN on the next edge, and RUN to RUN from then on. A second state machine drives the sync output. It has two states: SY_IDLE (output high) and SY_WINDOW (output low). It enters SY_WINDOW when both banks are the same number of cycles away from their next rising edge. It returns to SY_IDLE when those distances differ or the dividers are not active.

The ratio inputs are sampled only at a common edge. A ratio change therefore never cuts a pulse short. The ratio is DIV_W bits wide, and the values 0 and 1 are raised to 2.

Top module: `dual_div_sync`

## Requirements
- R1: While reset is asserted, and for the first reference cycle after release, clk_a_o and clk_c_o are 0 and sync_no is 1.
- R2: On the second rising reference edge after reset release, both outputs rise together. This is the first common edge. It is preceded by no sync pulse: sync_no is 1 after it unless the two ratios are equal.
- R3: A bank with effective ratio N produces a clock of period N reference cycles. Its rising edge falls on each phase wrap. For even N the output is high for N/2 cycles and low for N/2 cycles.
- R4: For odd N, the output is high for (N-1)/2 cycles and then low for (N+1)/2 cycles.
- R5: With unequal ratios, sync_no is 0 for exactly min(NA, NC) reference cycles right before each common rising edge after the first. At every other time it is 1.
- R6: sync_no returns to 1 on the same reference edge on which both outputs rise together. It rises at no other edge.
- R7: The ratio inputs are sampled only on a common edge, and the new ratios govern both banks from that edge on. Input changes between common edges have no effect on any output.
- R8: A ratio input of 0 or 1 acts as a ratio of 2. Every value from 2 to 2^DIV_W-1 is used as given.
- R9: If one ratio divides the other, common edges recur every period of the slower output, with one pulse before each. If the ratios are equal, the windows abut, and sync_no stays 0 from the first common edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_a_i | input | DIV_W | Requested divide ratio for bank A |
| ratio_c_i | input | DIV_W | Requested divide ratio for bank C |
| clk_a_o | output | 1 | Divided clock of bank A |
| clk_c_o | output | 1 | Divided clock of bank C |
| sync_no | output | 1 | Active-low pulse marking the next common rising edge |

## Verification
A wrong phase count or ratio register shows at the ports within one output period. It appears as a high or low phase of the wrong length, or as banks that no longer rise together at the expected common edge. A wrong distance comparison or sync state shows by the next common edge at the latest. The pulse then starts early or late, lasts longer or shorter than the faster period, or ends away from the shared rising edge. A ratio applied at the wrong moment changes the output periods before the boundary the bench predicts, so the very next cycle differs from the expected waveform.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        CTL_HOLD,
        CTL_ALIGN,
        CTL_RUN
    } ctl_state_e;

    typedef enum logic {
        SY_IDLE,
        SY_WINDOW
    } sync_state_e;

    localparam int MIN_RATIO = 2;

endpackage

// File: rtl/dds_bank.sv
module dds_bank
    import dds_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             boundary_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             clk_o,
    output logic [DIV_W-1:0] ratio_o,
    output logic [DIV_W-1:0] dist_o,
    output logic             wrap_o
);

    localparam logic [DIV_W-1:0] RATIO_FLOOR = DIV_W'(MIN_RATIO);
    localparam logic [DIV_W-1:0] ONE         = DIV_W'(1);

    logic [DIV_W-1:0] ratio_q, ratio_nxt, ratio_legal;
    logic [DIV_W-1:0] cnt_q, cnt_nxt;
    logic             clk_q, clk_nxt;

    // Ratios below the floor are raised to it.
    always_comb begin
        ratio_legal = (ratio_i < RATIO_FLOOR) ? RATIO_FLOOR : ratio_i;
    end

    // Phase wrap on the coming edge.
    assign wrap_o = run_i && (cnt_q == (ratio_q - ONE));

    always_comb begin
        ratio_nxt = ratio_q;
        cnt_nxt   = cnt_q;
        if (start_i || boundary_i) begin
            ratio_nxt = ratio_legal;
        end
        if (start_i) begin
            cnt_nxt = '0;
        end else if (run_i) begin
            cnt_nxt = wrap_o ? '0 : (cnt_q + ONE);
        end
    end

    // Cycles from the next state until the following rising edge.
    assign dist_o = ratio_nxt - cnt_nxt;

    always_comb begin
        if (start_i || run_i) begin
            clk_nxt = (cnt_nxt < (ratio_nxt >> 1));
        end else begin
            clk_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ratio_q <= RATIO_FLOOR;
            cnt_q   <= '0;
            clk_q   <= 1'b0;
        end else begin
            ratio_q <= ratio_nxt;
            cnt_q   <= cnt_nxt;
            clk_q   <= clk_nxt;
        end
    end

    assign clk_o   = clk_q;
    assign ratio_o = ratio_q;

endmodule

// File: rtl/dds_sync.sv
module dds_sync
    import dds_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             active_i,
    input  logic [DIV_W-1:0] dist_a_i,
    input  logic [DIV_W-1:0] dist_c_i,
    output logic             sync_no
);

    sync_state_e state_q, state_d;
    logic        same_dist;

    assign same_dist = (dist_a_i == dist_c_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SY_IDLE: begin
                if (active_i && same_dist) begin
                    state_d = SY_WINDOW;
                end
            end
            SY_WINDOW: begin
                if (!active_i || !same_dist) begin
                    state_d = SY_IDLE;
                end
            end
            default: state_d = SY_IDLE;
        endcase
    end

    always_comb begin
        sync_no = (state_q == SY_IDLE);
    end

endmodule

// File: rtl/dual_div_sync.sv
module dual_div_sync
    import dds_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic             clk_ref_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] ratio_a_i,
    input  logic [DIV_W-1:0] ratio_c_i,
    output logic             clk_a_o,
    output logic             clk_c_o,
    output logic             sync_no
);

    localparam int NBANK = 2;

    ctl_state_e state_q, state_d;
    logic       start_w, run_w, boundary_w;

    logic [NBANK-1:0][DIV_W-1:0] ratio_in;
    logic [NBANK-1:0][DIV_W-1:0] ratio_act;
    logic [NBANK-1:0][DIV_W-1:0] dist_nxt;
    logic [NBANK-1:0]            wrap_w;
    logic [NBANK-1:0]            clk_w;

    assign ratio_in[0] = ratio_a_i;
    assign ratio_in[1] = ratio_c_i;

    always_ff @(posedge clk_ref_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CTL_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_HOLD:  state_d = CTL_ALIGN;
            CTL_ALIGN: state_d = CTL_RUN;
            CTL_RUN:   state_d = CTL_RUN;
            default:   state_d = CTL_HOLD;
        endcase
    end

    always_comb begin
        start_w = (state_q == CTL_ALIGN);
        run_w   = (state_q == CTL_RUN);
    end

    // Common edge: every bank wraps on the same coming edge.
    assign boundary_w = &wrap_w;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        dds_bank #(
            .DIV_W(DIV_W)
        ) u_bank (
            .clk_i      (clk_ref_i),
            .rst_ni     (rst_ni),
            .start_i    (start_w),
            .boundary_i (boundary_w),
            .run_i      (run_w),
            .ratio_i    (ratio_in[g]),
            .clk_o      (clk_w[g]),
            .ratio_o    (ratio_act[g]),
            .dist_o     (dist_nxt[g]),
            .wrap_o     (wrap_w[g])
        );
    end

    dds_sync #(
        .DIV_W(DIV_W)
    ) u_sync (
        .clk_i    (clk_ref_i),
        .rst_ni   (rst_ni),
        .active_i (start_w | run_w),
        .dist_a_i (dist_nxt[0]),
        .dist_c_i (dist_nxt[1]),
        .sync_no  (sync_no)
    );

    assign clk_a_o = clk_w[0];
    assign clk_c_o = clk_w[1];

endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
    parameter int DIV_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic             clk_a_i,
    input logic             clk_c_i,
    input logic             sync_ni,
    input logic [DIV_W-1:0] ratio_a_i,
    input logic [DIV_W-1:0] ratio_c_i
);

    logic [DIV_W:0] low_run;
    logic [DIV_W:0] min_ratio;

    assign min_ratio = (ratio_a_i < ratio_c_i) ? {1'b0, ratio_a_i} : {1'b0, ratio_c_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            low_run <= '0;
        end else if (sync_ni) begin
            low_run <= '0;
        end else if (!(&low_run)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r2_quiet_before_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (!clk_a_i && !clk_c_i && sync_ni));

    a_r8_ratio_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio_a_i >= DIV_W'(2)) && (ratio_c_i >= DIV_W'(2)));

    a_r7_ratio_at_common_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(ratio_a_i) || !$stable(ratio_c_i)) |-> ($rose(clk_a_i) && $rose(clk_c_i)));

    a_r6_release_on_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_ni) |-> ($rose(clk_a_i) && $rose(clk_c_i)));

    a_r6_edges_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(clk_a_i) && $rose(clk_c_i) && $past(run_i) && (ratio_a_i != ratio_c_i))
        |-> $rose(sync_ni));

    a_r5_window_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_ni && (ratio_a_i != ratio_c_i)) |-> (low_run < min_ratio));

endmodule

bind dual_div_sync dds_checker #(
    .DIV_W(DIV_W)
) chk_i (
    .clk_i     (clk_ref_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .clk_a_i   (clk_a_o),
    .clk_c_i   (clk_c_o),
    .sync_ni   (sync_no),
    .ratio_a_i (ratio_act[0]),
    .ratio_c_i (ratio_act[1])
);

// File: tb/dual_div_sync_tb_top.sv
`timescale 1ns/1ps
module dual_div_sync_tb_top;

    localparam int DIV_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] ratio_a = 5'd2;
    logic [DIV_W-1:0] ratio_c = 5'd2;
    logic             clk_a, clk_c, sync_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dual_div_sync #(.DIV_W(DIV_W)) dut_i (
        .clk_ref_i (clk),
        .rst_ni    (rst_n),
        .ratio_a_i (ratio_a),
        .ratio_c_i (ratio_c),
        .clk_a_o   (clk_a),
        .clk_c_o   (clk_c),
        .sync_no   (sync_n)
    );

    function automatic int legal(int r);
        return (r < 2) ? 2 : r;
    endfunction

    function automatic int lcm(int a, int b);
        int x = a;
        int y = b;
        int tmp;
        while (y != 0) begin
            tmp = x % y;
            x   = y;
            y   = tmp;
        end
        return (a / x) * b;
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // R1: idle levels during reset and the first cycle after release.
    task automatic do_reset(int a, int c);
        rst_n   = 1'b0;
        ratio_a = DIV_W'(a);
        ratio_c = DIV_W'(c);
        repeat (3) @(negedge clk);
        check("R1", "clk_a in reset", clk_a, 1'b0);
        check("R1", "clk_c in reset", clk_c, 1'b0);
        check("R1", "sync in reset", sync_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "clk_a after release", clk_a, 1'b0);
        check("R1", "clk_c after release", clk_c, 1'b0);
        check("R1", "sync after release", sync_n, 1'b1);
    endtask

    // Reset, then follow the expected waveform cycle by cycle.
    task automatic run_pair(int a, int c, int a2, int c2, int change_at, int ncyc, string ctag);
        int  cur_a, cur_c, t, per, mn;
        logic ea, ec, es;
        string tg;
        do_reset(a, c);
        cur_a = legal(a);
        cur_c = legal(c);
        t     = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (i > 0) begin
                t++;
                if (t == lcm(cur_a, cur_c)) begin
                    t     = 0;
                    cur_a = legal(int'(ratio_a));
                    cur_c = legal(int'(ratio_c));
                end
            end
            per = lcm(cur_a, cur_c);
            mn  = (cur_a < cur_c) ? cur_a : cur_c;
            ea  = ((t % cur_a) < (cur_a / 2));
            ec  = ((t % cur_c) < (cur_c / 2));
            es  = !((per - t) <= mn);
            tg  = (i == 0) ? {"R2 ", ctag} : ctag;
            check(tg, "clk_a", clk_a, ea);
            check(tg, "clk_c", clk_c, ec);
            check({tg, " R5 R6"}, "sync", sync_n, es);
            if (i == change_at) begin
                ratio_a = DIV_W'(a2);
                ratio_c = DIV_W'(c2);
            end
        end
    endtask

    task automatic t_multiple_12_2();  run_pair(12, 2, 12, 2, -1, 60, "R3 R9"); endtask
    task automatic t_multiple_4_2();   run_pair(4, 2, 4, 2, -1, 40, "R3 R9");   endtask
    task automatic t_odd_5_3();        run_pair(5, 3, 5, 3, -1, 60, "R4");      endtask
    task automatic t_mixed_7_4();      run_pair(7, 4, 7, 4, -1, 90, "R3 R4");   endtask
    task automatic t_equal_6_6();      run_pair(6, 6, 6, 6, -1, 30, "R9");      endtask
    task automatic t_clamp_0_1();      run_pair(0, 1, 0, 1, -1, 20, "R8");      endtask
    task automatic t_clamp_1_9();      run_pair(1, 9, 1, 9, -1, 40, "R8 R4");   endtask
    task automatic t_change_mid();     run_pair(5, 3, 4, 6, 7, 80, "R7");       endtask
    task automatic t_change_to_eq();   run_pair(9, 4, 3, 3, 2, 60, "R7 R9");    endtask
    task automatic t_large_31_30();    run_pair(31, 30, 31, 30, -1, 1000, "R3 R4"); endtask

    initial begin
        t_multiple_12_2();
        t_multiple_4_2();
        t_odd_5_3();
        t_mixed_7_4();
        t_equal_6_6();
        t_clamp_0_1();
        t_clamp_1_9();
        t_change_mid();
        t_change_to_eq();
        t_large_31_30();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule